// File: doc/BRIEF.md
# Circular receive buffer write engine

This engine takes the payload of one received packet and writes it, word by word, into a circular region of word-addressed memory. Software describes the region with three byte quantities: a base pointer, a maximum buffer size and a start index. The engine turns each of them into a word quantity by dropping the byte-select bits. Writing begins at base plus start index. After the last word of the region the address returns to the base. If a packet carries more words than the region holds, the surplus words are still taken from the stream, so the channel empties, but they are not written, and a sticky overflow flag is raised.

A reception is taken only when three things are true in the same cycle: the engine is idle, a packet waits at the channel head, and the engine has been armed. Accepting a packet disarms the engine, so software must arm it again before the next packet. While a reception runs, the stream is always ready, configuration loads and arm strobes are ignored, and the done pulse at the end reports how many words were stored.

Top module: `rxw_engine`

## Requirements
- R1: A reception starts only in a cycle where the engine is idle, `pkt_avail` is high and the engine is armed. `busy` is high from the next cycle on. With any of the three missing, `busy` stays low and nothing is written.
- R2: Accepting a packet disarms the engine. An `arm` strobe counts only while idle and outside the accepting cycle. A strobe given while busy has no effect, so a waiting packet is not taken until `arm` is strobed again after done.
- R3: The first stored word goes to word address base + start index when the start index is below the maximum size, and to the base otherwise.
- R4: After a word is written at base + max − 1, the next stored word is written at the base, so every write address lies in [base, base + max).
- R5: Only the first max words of a packet are written (`mem_we` high). Later words are still accepted (`s_ready` high) and produce no write.
- R6: Any dropped word sets `overflow` in the next cycle. It stays set until `ovf_clr` is high in a cycle with no dropped word. A drop and a clear in the same cycle leave it set.
- R7: The base, maximum size and start index are given in bytes. The low log2(DATA_W/8) bits are ignored and the rest gives the word quantity.
- R8: In the cycle after the beat marked `s_last` is accepted, `done` is high for exactly one cycle, `busy` is low, and `stored_len` equals min(packet words, max).
- R9: `cfg_load` latches the configuration only while idle. A load during a reception changes neither that packet's addresses nor the configuration used afterwards.
- R10: `s_ready` equals `busy`. A cycle with `s_valid` low writes nothing and does not move the address.
- R11: After reset the engine is idle and disarmed. `busy`, `done`, `overflow`, `s_ready` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Latch the configuration inputs (idle only) |
| cfg_base | input | ADDR_W | Region base pointer in bytes |
| cfg_max | input | LEN_W+log2(DATA_W/8) | Region size in bytes |
| cfg_start | input | LEN_W+log2(DATA_W/8) | Start index in bytes |
| arm | input | 1 | Arm the engine for one packet (idle only) |
| pkt_avail | input | 1 | A packet waits at the channel head |
| s_valid | input | 1 | Stream word valid |
| s_data | input | DATA_W | Stream payload word |
| s_last | input | 1 | Marks the final word of the packet |
| s_ready | output | 1 | Stream ready, high while busy |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W−log2(DATA_W/8) | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| busy | output | 1 | Reception in progress |
| done | output | 1 | One-cycle end-of-packet pulse |
| stored_len | output | LEN_W | Words stored, valid with done |
| overflow | output | 1 | Sticky truncation flag |
| ovf_clr | input | 1 | Clear the overflow flag |

## Verification
Two actions can fall in the same cycle: a word being dropped, which sets the overflow flag, and software clearing that flag. The bench raises `ovf_clr` exactly on the first surplus beat of an over-length packet and expects the flag to be set after that cycle, and cleared only by a later clear given with no drop. A second overlap is a configuration load or arm strobe during a live reception. Both are judged by the addresses of the rest of the packet, and by whether the following packet starts and where it is written.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RECV = 1'b1
    } rxw_state_e;

    // What the current stream beat does to memory
    typedef enum logic [1:0] {
        BEAT_NONE  = 2'd0,
        BEAT_STORE = 2'd1,
        BEAT_DROP  = 2'd2
    } rxw_beat_e;

    function automatic int unsigned ceil_log2(input int unsigned n);
        int unsigned r;
        r = 0;
        while ((1 << r) < n) r++;
        return r;
    endfunction

endpackage

// File: rtl/rxw_cfg_regs.sv
module rxw_cfg_regs
    import rxw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    parameter int OFS_W  = 2,
    localparam int WA_W  = ADDR_W - OFS_W,
    localparam int BL_W  = LEN_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [BL_W-1:0]   cfg_max,
    input  logic [BL_W-1:0]   cfg_start,
    output logic [WA_W-1:0]   base_w,
    output logic [LEN_W-1:0]  max_w,
    output logic [LEN_W-1:0]  start_w
);

    // byte-select bits carry no meaning for a word memory
    logic unused_byte_sel;
    assign unused_byte_sel = ^{cfg_base[OFS_W-1:0], cfg_max[OFS_W-1:0], cfg_start[OFS_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_w  <= '0;
            max_w   <= '0;
            start_w <= '0;
        end else if (load_en) begin
            base_w  <= cfg_base[ADDR_W-1:OFS_W];
            max_w   <= cfg_max[BL_W-1:OFS_W];
            start_w <= cfg_start[BL_W-1:OFS_W];
        end
    end

endmodule

// File: rtl/rxw_addr_gen.sv
module rxw_addr_gen
    import rxw_pkg::*;
#(
    parameter int WA_W  = 14,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             begin_pkt,
    input  rxw_beat_e        beat,
    input  logic [WA_W-1:0]  base_w,
    input  logic [LEN_W-1:0] max_w,
    input  logic [LEN_W-1:0] start_w,
    output logic [WA_W-1:0]  mem_addr,
    output logic             room,
    output logic [LEN_W-1:0] count
);

    logic [LEN_W-1:0] offset;
    logic [LEN_W:0]   offset_inc;
    logic             at_end;

    assign offset_inc = {1'b0, offset} + {{LEN_W{1'b0}}, 1'b1};
    assign at_end     = (offset_inc == {1'b0, max_w});
    assign room       = (count < max_w);
    assign mem_addr   = base_w + WA_W'(offset);

    always_ff @(posedge clk) begin
        if (rst) begin
            offset <= '0;
            count  <= '0;
        end else if (begin_pkt) begin
            offset <= (start_w >= max_w) ? '0 : start_w;
            count  <= '0;
        end else if (beat == BEAT_STORE) begin
            offset <= at_end ? '0 : offset_inc[LEN_W-1:0];
            count  <= count + {{(LEN_W-1){1'b0}}, 1'b1};
        end
    end

endmodule

// File: rtl/rxw_ctrl.sv
module rxw_ctrl
    import rxw_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             pkt_avail,
    input  logic             s_valid,
    input  logic             s_last,
    input  logic             room,
    input  logic [LEN_W-1:0] count,
    input  logic             ovf_clr,
    output logic             busy,
    output logic             begin_pkt,
    output rxw_beat_e        beat,
    output logic             done,
    output logic [LEN_W-1:0] stored_len,
    output logic             overflow
);

    rxw_state_e state;
    logic       armed;
    logic       last_beat;

    assign busy      = (state == ST_RECV);
    assign begin_pkt = (state == ST_IDLE) && pkt_avail && armed;
    assign last_beat = busy && s_valid && s_last;

    always_comb begin
        beat = BEAT_NONE;
        if (busy && s_valid) beat = room ? BEAT_STORE : BEAT_DROP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            armed      <= 1'b0;
            done       <= 1'b0;
            stored_len <= '0;
            overflow   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (begin_pkt) begin
                        state <= ST_RECV;
                        armed <= 1'b0;
                    end else if (arm) begin
                        armed <= 1'b1;
                    end
                end
                ST_RECV: begin
                    if (last_beat) begin
                        state      <= ST_IDLE;
                        done       <= 1'b1;
                        stored_len <= count + ((beat == BEAT_STORE) ? {{(LEN_W-1){1'b0}}, 1'b1} : '0);
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (beat == BEAT_DROP)
                overflow <= 1'b1;
            else if (ovf_clr)
                overflow <= 1'b0;
        end
    end

endmodule

// File: rtl/rxw_engine.sv
module rxw_engine
    import rxw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    localparam int OFS_W = ceil_log2(DATA_W / 8),
    localparam int WA_W  = ADDR_W - OFS_W,
    localparam int BL_W  = LEN_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [BL_W-1:0]   cfg_max,
    input  logic [BL_W-1:0]   cfg_start,
    input  logic              arm,
    input  logic              pkt_avail,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              mem_we,
    output logic [WA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [LEN_W-1:0]  stored_len,
    output logic              overflow,
    input  logic              ovf_clr
);

    logic [WA_W-1:0]  base_w;
    logic [LEN_W-1:0] max_w;
    logic [LEN_W-1:0] start_w;
    logic             begin_pkt;
    logic             room;
    logic [LEN_W-1:0] count;
    rxw_beat_e        beat;

    rxw_cfg_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFS_W(OFS_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load_en  (cfg_load && !busy),
        .cfg_base (cfg_base),
        .cfg_max  (cfg_max),
        .cfg_start(cfg_start),
        .base_w   (base_w),
        .max_w    (max_w),
        .start_w  (start_w)
    );

    rxw_addr_gen #(.WA_W(WA_W), .LEN_W(LEN_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .begin_pkt(begin_pkt),
        .beat     (beat),
        .base_w   (base_w),
        .max_w    (max_w),
        .start_w  (start_w),
        .mem_addr (mem_addr),
        .room     (room),
        .count    (count)
    );

    rxw_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .pkt_avail (pkt_avail),
        .s_valid   (s_valid),
        .s_last    (s_last),
        .room      (room),
        .count     (count),
        .ovf_clr   (ovf_clr),
        .busy      (busy),
        .begin_pkt (begin_pkt),
        .beat      (beat),
        .done      (done),
        .stored_len(stored_len),
        .overflow  (overflow)
    );

    assign s_ready   = busy;
    assign mem_we    = (beat == BEAT_STORE);
    assign mem_wdata = s_data;

endmodule

// File: rtl/rxw_engine_chk.sv
module rxw_engine_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    localparam int OFS_W = rxw_pkg::ceil_log2(DATA_W / 8),
    localparam int WA_W  = ADDR_W - OFS_W
) (
    input logic             clk,
    input logic             rst,
    input logic             pkt_avail,
    input logic             s_valid,
    input logic             s_last,
    input logic             mem_we,
    input logic [WA_W-1:0]  mem_addr,
    input logic             busy,
    input logic             done,
    input logic             overflow,
    input logic             ovf_clr,
    input logic [WA_W-1:0]  base_w,
    input logic [LEN_W-1:0] max_w
);

    logic [WA_W-1:0] rel_addr;
    assign rel_addr = mem_addr - base_w;

    // R1
    idle_needs_packet_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !pkt_avail) |=> !busy);

    // R10
    write_needs_beat_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (busy && s_valid));

    // R4
    addr_in_region_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (rel_addr < WA_W'(max_w)));

    // R8
    last_ends_packet_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && s_valid && s_last) |=> (done && !busy));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overflow && !ovf_clr) |=> overflow);

    // R6
    overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!overflow && !(busy && s_valid && !mem_we)) |=> !overflow);

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(base_w) && $stable(max_w)));

endmodule

bind rxw_engine rxw_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pkt_avail(pkt_avail),
    .s_valid  (s_valid),
    .s_last   (s_last),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .busy     (busy),
    .done     (done),
    .overflow (overflow),
    .ovf_clr  (ovf_clr),
    .base_w   (base_w),
    .max_w    (max_w)
);

// File: tb/test_rxw_engine.sv
module test_rxw_engine;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int LEN_W  = 4;
    localparam int OFS_W  = 2;
    localparam int WA_W   = ADDR_W - OFS_W;
    localparam int BL_W   = LEN_W + OFS_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_load = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [BL_W-1:0]   cfg_max = '0;
    logic [BL_W-1:0]   cfg_start = '0;
    logic              arm = 1'b0;
    logic              pkt_avail = 1'b0;
    logic              s_valid = 1'b0;
    logic [DATA_W-1:0] s_data = '0;
    logic              s_last = 1'b0;
    logic              ovf_clr = 1'b0;
    logic              s_ready, mem_we, busy, done, overflow;
    logic [WA_W-1:0]   mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [LEN_W-1:0]  stored_len;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    rxw_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_rxw_engine (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_base(cfg_base),
        .cfg_max(cfg_max), .cfg_start(cfg_start), .arm(arm), .pkt_avail(pkt_avail),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
        .done(done), .stored_len(stored_len), .overflow(overflow), .ovf_clr(ovf_clr)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic configure(input int bw, input int mw, input int sw, input int junk);
        @(negedge clk);
        cfg_base  = ADDR_W'(bw * 4 + (junk % 4));
        cfg_max   = BL_W'(mw * 4 + ((junk + 1) % 4));
        cfg_start = BL_W'(sw * 4 + ((junk + 2) % 4));
        cfg_load  = 1'b1;
        @(negedge clk);
        cfg_load  = 1'b0;
    endtask

    task automatic do_arm();
        @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    // packet waits for three cycles; engine must not take it
    task automatic expect_no_start(input string req);
        @(negedge clk);
        pkt_avail = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            chk(req, "busy without start", busy, 0);
            chk(req, "mem_we without start", mem_we, 0);
        end
        pkt_avail = 1'b0;
    endtask

    task automatic run_packet(input int bw, input int mw, input int sw, input int len,
                              input bit gap, input bit clr_same, input bit disturb);
        int s0;
        int exp_len;
        s0 = (sw >= mw) ? 0 : sw;
        exp_len = (len < mw) ? len : mw;
        @(negedge clk);
        pkt_avail = 1'b1;
        @(negedge clk);
        pkt_avail = 1'b0;
        #1;
        chk("R1", "busy after accept", busy, 1);
        chk("R10", "s_ready while busy", s_ready, 1);
        for (int i = 0; i < len; i++) begin
            if (gap && i == 1) begin
                s_valid = 1'b0;
                #1;
                chk("R10", "no write on idle beat", mem_we, 0);
                @(negedge clk);
            end
            s_valid   = 1'b1;
            s_data    = DATA_W'(32'h5A00_0000 + len * 256 + i * 7);
            s_last    = (i == len - 1);
            ovf_clr   = clr_same && (i == mw);
            cfg_load  = disturb && (i == 0);
            arm       = disturb && (i == 0);
            if (disturb && i == 0) begin
                cfg_base  = ADDR_W'(12'h7F0);
                cfg_max   = BL_W'(6'h3C);
                cfg_start = BL_W'(6'h08);
            end
            #1;
            chk("R10", "s_ready on beat", s_ready, 1);
            if (i < mw) begin
                chk("R5", "write enable in region", mem_we, 1);
                if (i == 0)
                    chk("R3", "first address", mem_addr, (bw + s0) % (1 << WA_W));
                else
                    chk("R4", "wrapped address", mem_addr, (bw + ((s0 + i) % mw)) % (1 << WA_W));
                chk("R5", "write data", mem_wdata, s_data);
            end else begin
                chk("R5", "surplus word not written", mem_we, 0);
            end
            @(negedge clk);
        end
        s_valid  = 1'b0;
        s_last   = 1'b0;
        ovf_clr  = 1'b0;
        cfg_load = 1'b0;
        arm      = 1'b0;
        #1;
        chk("R8", "done pulse", done, 1);
        chk("R8", "busy low at done", busy, 0);
        chk("R8", "stored length", stored_len, exp_len);
        chk("R6", "overflow after packet", overflow, (len > mw) ? 1 : 0);
        @(negedge clk);
        #1;
        chk("R8", "done one cycle", done, 0);
        if (len > mw) begin
            ovf_clr = 1'b1;
            @(negedge clk);
            ovf_clr = 1'b0;
            #1;
            chk("R6", "overflow cleared", overflow, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R11", "busy in reset", busy, 0);
        chk("R11", "done in reset", done, 0);
        chk("R11", "overflow in reset", overflow, 0);
        chk("R11", "s_ready in reset", s_ready, 0);
        chk("R11", "mem_we in reset", mem_we, 0);
        rst = 1'b0;

        // not armed: no start
        expect_no_start("R1");

        // sweep of size, start index and length, with junk byte bits (R7)
        for (int m = 1; m <= 5; m++) begin
            for (int st = 0; st <= m; st++) begin
                for (int len = 1; len <= m + 2; len++) begin
                    int bw;
                    bw = (m * 37 + st * 5 + len * 11) % 900 + 8;
                    configure(bw, m, st, len + st);
                    do_arm();
                    run_packet(bw, m, st, len, len == 3, (len == m + 2) && (st == 0), 1'b0);
                end
            end
        end

        // disarmed after a packet
        expect_no_start("R2");

        // arm and load during reception are ignored
        configure(200, 4, 1, 3);
        do_arm();
        run_packet(200, 4, 1, 3, 1'b0, 1'b0, 1'b1);
        expect_no_start("R2");
        do_arm();
        run_packet(200, 4, 1, 6, 1'b0, 1'b0, 1'b0);

        // zero-size region: every word dropped
        configure(300, 0, 0, 1);
        do_arm();
        run_packet(300, 0, 0, 2, 1'b0, 1'b0, 1'b0);

        // largest region, start at the last word
        configure(500, 15, 14, 2);
        do_arm();
        run_packet(500, 15, 14, 16, 1'b1, 1'b1, 1'b0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule